// File: doc/BRIEF.md
# Serial Transmit Engine with Line Break

This block turns bytes into an asynchronous serial bit stream. Software writes a line control register that sets word length (5 to 8 bits), one or two stop bits, parity on or off, parity sense, a parity-corruption switch, a line-break switch and a bank-select bit. Bytes written to the data port queue in a small FIFO. The engine frames each byte as one low start bit, the data bits LSB first, an optional parity bit and one or two high stop bits. An external baud tick drives it, and each bit lasts a fixed number of ticks. When the FIFO is empty, the holding-empty flag is high.

All timing comes from a free-running grid of bit boundaries. The state machine has six states: `TX_IDLE` (line high), `TX_START`, `TX_DATA`, `TX_PARITY`, `TX_STOP` and `TX_BREAK` (line low). The state machine moves only at bit boundaries, with one exception covered below. The transitions are:
- `TX_IDLE` to `TX_START` loads the FIFO head.
- `TX_START` goes to `TX_DATA`.
- `TX_DATA` loops until the last data bit, then goes to `TX_PARITY` or `TX_STOP`.
- `TX_PARITY` goes to `TX_STOP`.
- `TX_STOP` loops once for a second stop bit, then goes to `TX_START` if another byte waits, or else to `TX_IDLE`.
- Any state other than `TX_BREAK` goes to `TX_BREAK` at a boundary while a break is requested. This entry flushes the FIFO and discards the byte being shifted.
- `TX_BREAK` goes to `TX_IDLE` on the first baud tick after the break bit is clear, once at least one full bit time has been spent low. This exit is the one move that does not wait for a bit boundary.

A break request is latched when the break bit is written to 1. Because of this latch, a break that is cleared again before its boundary still takes place.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset the control register reads 0x00, `txd` is high and `thr_empty` is high.
- R2: A frame is one low start bit, then 5 + `lcr[1:0]` data bits LSB first, then high stop bits. There are two stop bits when `lcr[2]`=1 and one when it is 0.
- R3: When `lcr[3]`=1, a parity bit follows the data bits. With `lcr[4]`=1 it makes the count of ones even; with `lcr[4]`=0 it makes the count odd.
- R4: When `lcr[5]`=1 and `lcr[3]`=1, the parity bit sent is the complement of the correct one.
- R5: `thr_empty` is high exactly when the FIFO holds no bytes. A write to a full FIFO is dropped.
- R6: While `lcr[7]`=1, writes on the data port are ignored.
- R7: Writing `lcr[6]`=1 drives `txd` low from the next bit boundary. At that boundary the FIFO is flushed, and the byte in the shift register is never sent.
- R8: A break lasts at least one full bit time, even if `lcr[6]` is cleared before the break begins.
- R9: After `lcr[6]` is cleared, `txd` returns high on the next baud tick. Bytes written during the break are sent afterwards.
- R10: Each bit lasts `TICKS_PER_BIT` baud ticks, and queued bytes are sent back to back with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle baud generator tick |
| lcr_we | input | 1 | Line control register write strobe |
| lcr_wdata | input | 8 | Line control write data |
| lcr_rdata | output | 8 | Line control register contents |
| thr_we | input | 1 | Data write strobe |
| thr_wdata | input | 8 | Byte to queue |
| txd | output | 1 | Serial output, idle high |
| thr_empty | output | 1 | High when the FIFO is empty |

## Verification
The assertions assume that `baud_tick` is a clean one-cycle strobe and that `rst_n` is held for at least one clock edge. They also assume that a data write never lands in the same cycle as a break-entry flush, since the flush drops that write. The stimulus ticks every cycle and writes in the control register or data port only at negative clock edges. It queues bytes during a break only after `thr_empty` has been seen high, so a write never meets the flush.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP,
        TX_BREAK
    } tx_state_e;

    typedef struct packed {
        logic       bank;      // 7: data port redirected away
        logic       brk;       // 6: line break
        logic       par_flip;  // 5: corrupt parity
        logic       par_even;  // 4: even parity
        logic       par_en;    // 3: parity enable
        logic       stop_two;  // 2: two stop bits
        logic [1:0] wlen;      // 1:0: word length - 5
    } lcr_t;

endpackage

// File: rtl/uart_tx_bitclk.sv
module uart_tx_bitclk #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    assign bit_end = baud_tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (bit_end)  cnt_q <= '0;
        else if (baud_tick) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PMAX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PMAX) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == PMAX) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r5_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (cnt_q == $past(cnt_q)));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_end,
    input  logic       baud_tick,
    input  lcr_t       lcr,
    input  logic       brk_req,
    input  logic       fifo_empty,
    input  logic [7:0] fifo_head,
    output logic       pop,
    output logic       flush,
    output logic       in_break,
    output logic       txd
);
    tx_state_e  state_q, state_d;
    logic [7:0] shift_q;
    logic [2:0] idx_q, last_q;
    logic       par_q, pen_q, two_q, stop2nd_q, min_q;
    logic       do_load, do_shift, go_brk;
    logic [7:0] mask, masked;
    logic       par_calc;

    assign mask     = 8'hFF >> (3'd3 - {1'b0, lcr.wlen});
    assign masked   = fifo_head & mask;
    assign par_calc = (^masked) ^ ~lcr.par_even ^ lcr.par_flip;

    // next state
    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_shift = 1'b0;
        go_brk   = 1'b0;
        unique case (state_q)
            TX_IDLE: if (bit_end) begin
                if (brk_req)          go_brk = 1'b1;
                else if (!fifo_empty) do_load = 1'b1;
            end
            TX_START: if (bit_end) begin
                if (brk_req) go_brk = 1'b1;
                else         state_d = TX_DATA;
            end
            TX_DATA: if (bit_end) begin
                if (brk_req)              go_brk = 1'b1;
                else if (idx_q == last_q) state_d = pen_q ? TX_PARITY : TX_STOP;
                else                      do_shift = 1'b1;
            end
            TX_PARITY: if (bit_end) begin
                if (brk_req) go_brk = 1'b1;
                else         state_d = TX_STOP;
            end
            TX_STOP: if (bit_end) begin
                if (brk_req)                 go_brk = 1'b1;
                else if (two_q && !stop2nd_q) state_d = TX_STOP;
                else if (!fifo_empty)        do_load = 1'b1;
                else                         state_d = TX_IDLE;
            end
            TX_BREAK:
                if (baud_tick && !lcr.brk && (min_q || bit_end)) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
        if (go_brk)  state_d = TX_BREAK;
        if (do_load) state_d = TX_START;
    end

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= TX_IDLE;
            shift_q   <= '0;
            idx_q     <= '0;
            last_q    <= 3'd7;
            par_q     <= 1'b0;
            pen_q     <= 1'b0;
            two_q     <= 1'b0;
            stop2nd_q <= 1'b0;
            min_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (do_load) begin
                shift_q <= fifo_head;
                idx_q   <= '0;
                last_q  <= 3'd4 + {1'b0, lcr.wlen};
                par_q   <= par_calc;
                pen_q   <= lcr.par_en;
                two_q   <= lcr.stop_two;
            end else if (do_shift) begin
                shift_q <= shift_q >> 1;
                idx_q   <= idx_q + 1'b1;
            end
            if (state_q == TX_STOP && state_d == TX_STOP && bit_end) stop2nd_q <= 1'b1;
            else if (state_d != TX_STOP)                             stop2nd_q <= 1'b0;
            if (go_brk)                                   min_q <= 1'b0;
            else if (state_q == TX_BREAK && bit_end)      min_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shift_q[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   txd = 1'b1;
            TX_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
    end

    assign pop      = do_load;
    assign flush    = go_brk;
    assign in_break = (state_q == TX_BREAK);

    a_r3_parity_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_PARITY) |-> pen_q);

    a_r2_start_after_idle_or_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == TX_START) |-> ($past(state_q) == TX_IDLE || $past(state_q) == TX_STOP));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int FIFO_DEPTH    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       lcr_we,
    input  logic [7:0] lcr_wdata,
    output logic [7:0] lcr_rdata,
    input  logic       thr_we,
    input  logic [7:0] thr_wdata,
    output logic       txd,
    output logic       thr_empty
);
    lcr_t       lcr_q;
    logic       brk_pend_q;
    logic       bit_end, pop, flush, in_break, fifo_full;
    logic [7:0] head;
    lcr_t       lcr_w;

    assign lcr_w     = lcr_t'(lcr_wdata);
    assign lcr_rdata = lcr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q      <= '0;
            brk_pend_q <= 1'b0;
        end else begin
            if (lcr_we) lcr_q <= lcr_w;
            if (lcr_we && lcr_w.brk) brk_pend_q <= 1'b1;
            else if (flush)          brk_pend_q <= 1'b0;
        end
    end

    uart_tx_bitclk #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_bitclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    uart_tx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (thr_we && !lcr_q.bank),
        .wdata (thr_wdata),
        .pop   (pop),
        .flush (flush),
        .rdata (head),
        .empty (thr_empty),
        .full  (fifo_full)
    );

    uart_tx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_end    (bit_end),
        .baud_tick  (baud_tick),
        .lcr        (lcr_q),
        .brk_req    (brk_pend_q || lcr_q.brk),
        .fifo_empty (thr_empty),
        .fifo_head  (head),
        .pop        (pop),
        .flush      (flush),
        .in_break   (in_break),
        .txd        (txd)
    );

    a_r10_txd_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));

    a_r7_flush_on_break: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_break) |-> thr_empty);

    a_r9_exit_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_break) |-> !$past(lcr_q.brk));

    a_r6_bank_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty && lcr_q.bank && !pop) |=> thr_empty);
endmodule

// File: tb/uart_tx_brk_tb.sv
module uart_tx_brk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic       lcr_we = 1'b0;
    logic [7:0] lcr_wdata = '0;
    logic [7:0] lcr_rdata;
    logic       thr_we = 1'b0;
    logic [7:0] thr_wdata = '0;
    logic       txd, thr_empty;

    int checks = 0;
    int failures = 0;
    logic [7:0] cur_lcr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_brk #(.TICKS_PER_BIT(TPB), .FIFO_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .lcr_we(lcr_we), .lcr_wdata(lcr_wdata), .lcr_rdata(lcr_rdata),
        .thr_we(thr_we), .thr_wdata(thr_wdata),
        .txd(txd), .thr_empty(thr_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_lcr(input logic [7:0] v);
        @(negedge clk);
        lcr_we = 1'b1; lcr_wdata = v; cur_lcr = v;
        @(negedge clk);
        lcr_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        thr_we = 1'b1; thr_wdata = b;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic rx_frame(input logic [7:0] exp, input string req);
        int t;
        int nb;
        logic [7:0] d, mask;
        logic p, ep;
        nb = 5 + int'(cur_lcr[1:0]);
        mask = 8'hFF >> (8 - nb);
        t = 0;
        while (txd !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
        check(t < 3000, "R2 start seen", t, 0);
        repeat (TPB/2) @(negedge clk);
        check(txd == 1'b0, "R2 start bit low", int'(txd), 0);
        d = '0;
        for (int i = 0; i < nb; i++) begin
            repeat (TPB) @(negedge clk);
            d[i] = txd;
        end
        check(d == (exp & mask), {req, " R2 R10 data"}, int'(d), int'(exp & mask));
        if (cur_lcr[3]) begin
            repeat (TPB) @(negedge clk);
            p  = txd;
            ep = (^(exp & mask)) ^ ~cur_lcr[4] ^ cur_lcr[5];
            check(p == ep, {req, " R3 R4 parity"}, int'(p), int'(ep));
        end
        for (int s = 0; s < (cur_lcr[2] ? 2 : 1); s++) begin
            repeat (TPB) @(negedge clk);
            check(txd == 1'b1, "R2 stop bit high", int'(txd), 1);
        end
    endtask

    task automatic expect_idle(input int n, input string req);
        int lows;
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
        check(lows == 0, req, lows, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(lcr_rdata == 8'h00, "R1 lcr reset", int'(lcr_rdata), 0);
        check(txd == 1'b1, "R1 txd idle", int'(txd), 1);
        check(thr_empty == 1'b1, "R1 empty", int'(thr_empty), 1);
    endtask

    task automatic t_8n1;
        write_lcr(8'h03);
        push(8'hA5);
        push(8'h3C);
        rx_frame(8'hA5, "R2 8N1 first");
        rx_frame(8'h3C, "R10 8N1 back to back");
        check(thr_empty == 1'b1, "R5 empty after drain", int'(thr_empty), 1);
    endtask

    task automatic t_5bit_2stop;
        write_lcr(8'h04);
        push(8'h13);
        push(8'h0E);
        rx_frame(8'h13, "R2 5 bit 2 stop");
        rx_frame(8'h0E, "R2 5 bit 2 stop second");
    endtask

    task automatic t_parity;
        write_lcr(8'h1A);
        push(8'h35);
        rx_frame(8'h35, "R3 7 bit even");
        write_lcr(8'h0B);
        push(8'h81);
        rx_frame(8'h81, "R3 8 bit odd");
    endtask

    task automatic t_force;
        write_lcr(8'h3B);
        push(8'h5A);
        rx_frame(8'h5A, "R4 forced even");
        write_lcr(8'h2B);
        push(8'h07);
        rx_frame(8'h07, "R4 forced odd");
    endtask

    task automatic t_bank;
        write_lcr(8'h83);
        push(8'h55);
        check(thr_empty == 1'b1, "R6 write ignored", int'(thr_empty), 1);
        expect_idle(5 * TPB, "R6 no frame sent");
        write_lcr(8'h03);
    endtask

    task automatic t_break_flush;
        int t;
        write_lcr(8'h03);
        push(8'hA5);
        push(8'h3C);
        t = 0;
        while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
        write_lcr(8'h43);
        check(thr_empty == 1'b0, "R5 byte still queued", int'(thr_empty), 0);
        t = 0;
        while (thr_empty !== 1'b1 && t < 100) begin @(negedge clk); t++; end
        check(t >= 1 && t <= TPB, "R7 flush at boundary", t, TPB);
        t = 0;
        for (int i = 0; i < 3 * TPB; i++) begin
            @(negedge clk);
            if (txd == 1'b1) t++;
        end
        check(t == 0, "R7 line held low", t, 0);
        for (int i = 0; i < DEPTH + 2; i++) push(8'h10 + 8'(i));
        check(thr_empty == 1'b0, "R9 bytes queued in break", int'(thr_empty), 0);
        write_lcr(8'h03);
        t = 0;
        while (txd !== 1'b1 && t < 100) begin @(negedge clk); t++; end
        check(t <= 2, "R9 release on next tick", t, 1);
        for (int i = 0; i < DEPTH; i++) rx_frame(8'h10 + 8'(i), "R9 sent after break");
        expect_idle(15 * TPB, "R5 R7 no dropped or flushed byte");
    endtask

    task automatic t_short_break;
        int t;
        write_lcr(8'h43);
        write_lcr(8'h03);
        t = 0;
        while (txd !== 1'b0 && t < 3 * TPB) begin @(negedge clk); t++; end
        check(t < 3 * TPB, "R8 short break started", t, 0);
        t = 0;
        while (txd !== 1'b1 && t < 10 * TPB) begin @(negedge clk); t++; end
        check(t == TPB, "R8 one bit time low", t, TPB);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_8n1();
        t_5bit_2stop();
        t_parity();
        t_force();
        t_bank();
        t_break_flush();
        t_short_break();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule